// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous host request port to an asynchronous DRAM of 262144 sixteen-bit words. The DRAM has nine multiplexed address pins, one row strobe, two column strobes (one per byte lane), one write enable and one output enable. The host presents an 18-bit word address, write data, two byte enables and a read/write flag with a valid/ready handshake. The controller splits the address into a row and a column and drives the strobes in the order the memory expects. It returns read data with a single-cycle valid pulse.

After an access the row stays open. A later request to the same row then runs as a short column-only cycle. The row is closed on three events: a request to a different row, a pending refresh, or the row-low timer nearing its maximum. Each closing is followed by the full precharge time. Refreshes are requested by an external scheduler and run as column-before-row cycles, which the memory counts internally. The controller acknowledges each refresh with a grant pulse.

Every analog timing limit is a nanosecond parameter. The controller turns each one into a clock count by rounding up. The data pins are split into a driven value, a drive enable and an input, so that the tristate buffer can sit outside the block.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, every strobe (row, both column, write enable, output enable) is high, the data drive enable is low, rd_valid and ref_gnt are low, and req_ready is high.
- R2: The row half of the word address (req_addr[17:9]) is on dram_addr when the row strobe falls. The column half (req_addr[8:0]) is on dram_addr when the column strobes fall.
- R3: A write is an early write. Write enable is already low in the cycle before the column strobes fall. During the strobe, output enable stays high and the data drive enable is high.
- R4: On a write, the lower column strobe falls only if req_be[0] is set and writes bits 7:0. The upper strobe falls only if req_be[1] is set and writes bits 15:8. A read drops both strobes.
- R5: On a read, output enable is low while the column strobes are low. The word read is returned on rd_data with rd_valid high for exactly one cycle, in request order.
- R6: A request to the row that is already open is served without a new row strobe fall.
- R7: A request to another row raises the row strobe. The strobe stays high for at least the precharge count (4 cycles at the default timing) before the next fall.
- R8: Between the row strobe falling and the column strobes falling there are at least the RAS-to-CAS count of cycles (2 by default). A column strobe stays low for at least the CAS pulse count (2 by default).
- R9: The row strobe never stays low longer than the maximum RAS-low time in cycles, even when the host is idle.
- R10: While ref_req is high, req_ready is low. A refresh drops both column strobes before the row strobe, keeps write enable high, and ends with a one-cycle ref_gnt pulse.
- R11: The data drive enable and a low output enable never coincide. Output enable falls only when the drive enable was already low in the previous cycle.
- R12: Every row strobe low period lasts at least the minimum active count (6 cycles by default, derived from the cycle time and the precharge time).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in [17:9], column in [8:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| rd_data | output | 16 | Returned read word |
| ref_req | input | 1 | Refresh request from the scheduler |
| ref_gnt | output | 1 | One-cycle pulse when a refresh completes |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed address pins |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable of the external data buffer |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The bench goes after page hits against misses. A controller that compares rows wrongly would either reopen the row on every access or serve a different row's data without a new strobe. Partial-byte writes are checked by reading the merged word back: swapped or missing strobe lanes corrupt the wrong byte. A row is left open while the host is idle, and also while a refresh arrives, to catch a controller that forgets the RAS-low limit or runs a refresh over an open row. A behavioural memory watches every strobe edge for short precharge, short RAS-to-CAS delay, late write enable and bus fights, and flags a row or column driven in the wrong phase.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int ROW_W  = 9;
    localparam int COL_W  = 9;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;
    localparam int CNT_W  = 8;

    typedef enum logic [3:0] {
        S_IDLE,  // row closed, precharge done
        S_ACT,   // row strobe low, row address held
        S_CSET,  // column address and write enable set up
        S_COL,   // column strobes low
        S_CPRE,  // column precharge
        S_OPEN,  // row open, waiting for a hit
        S_PRE,   // row precharge
        S_RCAS,  // refresh: column strobes low first
        S_RRAS   // refresh: row strobe low
    } fpm_st_e;

    typedef struct packed {
        fpm_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic                ras_n;
        logic                lcas_n;
        logic                ucas_n;
        logic                we_n;
        logic                oe_n;
        logic [ROW_W-1:0]    a;
        logic                dq_oe;
        logic [DATA_W-1:0]   wd;
        logic [BE_W-1:0]     be;
        logic                wr;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic                open;
        logic                rvalid;
        logic [DATA_W-1:0]   rdata;
        logic                gnt;
    } fpm_regs_t;
endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split
    import fpm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              row_open,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              hit
);
    assign row = addr[ADDR_W-1:COL_W];
    assign col = addr[COL_W-1:0];
    assign hit = row_open && (row == open_row);
endmodule

// File: rtl/fpm_raswatch.sv
module fpm_raswatch #(
    parameter int MIN_C = 6,
    parameter int EXP_C = 95,
    parameter int MAX_C = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic min_ok,
    output logic expire
);
    localparam int W = $clog2(MAX_C + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (ras_n)
            cnt_d = '0;
        else if (cnt_q != W'(MAX_C))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // count = cycles low so far; closing now adds one more cycle
    assign min_ok = (cnt_q >= W'(MIN_C - 1));
    assign expire = (cnt_q >= W'(EXP_C));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int T_RCD_NS    = 20,
    parameter int T_RAH_NS    = 10,
    parameter int T_RP_NS     = 35,
    parameter int T_RAS_NS    = 50,
    parameter int T_RC_NS     = 95,
    parameter int T_CAS_NS    = 15,
    parameter int T_CP_NS     = 10,
    parameter int T_PC_NS     = 35,
    parameter int T_RAC_NS    = 50,
    parameter int T_CAC_NS    = 15,
    parameter int T_AA_NS     = 25,
    parameter int T_CSR_NS    = 5,
    parameter int T_CHR_NS    = 10,
    parameter int T_RASMAX_NS = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [17:0]       req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [8:0]        dram_addr,
    output logic [15:0]       dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [15:0]       dram_dq_in
);
    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RCD_C    = cyc(T_RCD_NS);
    localparam int RAH_C    = cyc(T_RAH_NS);
    localparam int RP_C     = cyc(T_RP_NS);
    localparam int RAS_C    = cyc(T_RAS_NS);
    localparam int RC_C     = cyc(T_RC_NS);
    localparam int CAS_C    = cyc(T_CAS_NS);
    localparam int CP_C     = cyc(T_CP_NS);
    localparam int PC_C     = cyc(T_PC_NS);
    localparam int RAC_C    = cyc(T_RAC_NS);
    localparam int CAC_C    = cyc(T_CAC_NS);
    localparam int AA_C     = cyc(T_AA_NS);
    localparam int CSR_C    = cyc(T_CSR_NS);
    localparam int CHR_C    = cyc(T_CHR_NS);
    localparam int RASMAX_C = cyc(T_RASMAX_NS);
    // column strobe width covers pulse width, CAS access and column access
    localparam int COLW_C   = mx(mx(CAS_C, CAC_C), AA_C - 1);
    // row-held cycles before column setup: RCD, row hold and RAS access
    localparam int ACTW_C   = mx(mx(RCD_C - 1, RAH_C), mx(RAC_C - 1 - COLW_C, 1));
    localparam int CPW_C    = mx(CP_C, PC_C - 1 - COLW_C);
    localparam int RAS_MIN_C = mx(RAS_C, RC_C - RP_C);
    localparam int PAGE_C   = 1 + COLW_C + CPW_C;
    localparam int EXP_C    = RASMAX_C - PAGE_C - 1;

    fpm_regs_t d, q;
    logic [ROW_W-1:0] s_row;
    logic [COL_W-1:0] s_col;
    logic             hit, min_ok, expire, ready;

    fpm_addr_split u_split (
        .addr     (req_addr),
        .open_row (q.row),
        .row_open (q.open),
        .row      (s_row),
        .col      (s_col),
        .hit      (hit)
    );

    fpm_raswatch #(.MIN_C(RAS_MIN_C), .EXP_C(EXP_C), .MAX_C(RASMAX_C)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ras_n  (q.ras_n),
        .min_ok (min_ok),
        .expire (expire)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        d.gnt    = 1'b0;
        ready    = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                ready = !ref_req;
                if (ref_req) begin
                    d.st     = S_RCAS;
                    d.lcas_n = 1'b0;
                    d.ucas_n = 1'b0;
                    d.cnt    = CNT_W'(CSR_C - 1);
                end else if (req_valid) begin
                    d.wr    = req_write;
                    d.wd    = req_wdata;
                    d.be    = req_be;
                    d.row   = s_row;
                    d.col   = s_col;
                    d.open  = 1'b1;
                    d.ras_n = 1'b0;
                    d.a     = s_row;
                    d.st    = S_ACT;
                    d.cnt   = CNT_W'(ACTW_C - 1);
                end
            end
            S_ACT: begin
                if (q.cnt == '0) begin
                    d.st    = S_CSET;
                    d.a     = q.col;
                    d.we_n  = !q.wr;
                    d.dq_oe = q.wr;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_CSET: begin
                d.st     = S_COL;
                d.lcas_n = q.wr ? !q.be[0] : 1'b0;
                d.ucas_n = q.wr ? !q.be[1] : 1'b0;
                d.oe_n   = q.wr;
                d.cnt    = CNT_W'(COLW_C - 1);
            end
            S_COL: begin
                if (q.cnt == '0) begin
                    d.st     = S_CPRE;
                    d.lcas_n = 1'b1;
                    d.ucas_n = 1'b1;
                    d.oe_n   = 1'b1;
                    d.we_n   = 1'b1;
                    d.dq_oe  = 1'b0;
                    d.cnt    = CNT_W'(CPW_C - 1);
                    if (!q.wr) begin
                        d.rvalid = 1'b1;
                        d.rdata  = dram_dq_in;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_CPRE: begin
                if (q.cnt == '0) d.st  = S_OPEN;
                else             d.cnt = q.cnt - 1'b1;
            end
            S_OPEN: begin
                ready = hit && !ref_req && !expire;
                if ((ref_req || expire || (req_valid && !hit)) && min_ok) begin
                    d.st    = S_PRE;
                    d.ras_n = 1'b1;
                    d.open  = 1'b0;
                    d.cnt   = CNT_W'(RP_C - 1);
                end else if (ready && req_valid) begin
                    d.wr    = req_write;
                    d.wd    = req_wdata;
                    d.be    = req_be;
                    d.a     = s_col;
                    d.we_n  = !req_write;
                    d.dq_oe = req_write;
                    d.st    = S_CSET;
                end
            end
            S_PRE: begin
                if (q.cnt == '0) d.st  = S_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            S_RCAS: begin
                if (q.cnt == '0) begin
                    d.st    = S_RRAS;
                    d.ras_n = 1'b0;
                    d.cnt   = CNT_W'(RAS_MIN_C - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_RRAS: begin
                if (q.cnt == '0) begin
                    d.st     = S_PRE;
                    d.ras_n  = 1'b1;
                    d.lcas_n = 1'b1;
                    d.ucas_n = 1'b1;
                    d.gnt    = 1'b1;
                    d.cnt    = CNT_W'(RP_C - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                    if (d.cnt <= CNT_W'(RAS_MIN_C - 1 - CHR_C)) begin
                        d.lcas_n = 1'b1;
                        d.ucas_n = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.ras_n  <= 1'b1;
            q.lcas_n <= 1'b1;
            q.ucas_n <= 1'b1;
            q.we_n   <= 1'b1;
            q.oe_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = ready;
    assign rd_valid    = q.rvalid;
    assign rd_data     = q.rdata;
    assign ref_gnt     = q.gnt;
    assign dram_ras_n  = q.ras_n;
    assign dram_lcas_n = q.lcas_n;
    assign dram_ucas_n = q.ucas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.a;
    assign dram_dq_out = q.wd;
    assign dram_dq_oe  = q.dq_oe;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int RASMAX_C  = 100,
    parameter int RP_C      = 4,
    parameter int RAS_MIN_C = 6,
    parameter int RCD_C     = 2
) (
    input logic clk,
    input logic rst_n,
    input logic rd_valid,
    input logic ref_gnt,
    input logic dram_ras_n,
    input logic dram_lcas_n,
    input logic dram_ucas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    logic [31:0] lowc, hic;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lowc <= '0;
            hic  <= 32'(RP_C);
        end else begin
            lowc <= dram_ras_n ? '0 : lowc + 1;
            hic  <= dram_ras_n ? hic + 1 : '0;
        end
    end

    a_r9_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
        lowc <= 32'(RASMAX_C));

    a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> hic >= 32'(RP_C));

    a_r12_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> lowc >= 32'(RAS_MIN_C));

    a_r8_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n) |-> lowc >= 32'(RCD_C));

    a_r11_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

    a_r11_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_oe_n) |-> !$past(dram_dq_oe));

    a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> !$past(dram_we_n));

    a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_refresh_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !(dram_lcas_n && dram_ucas_n)) |-> dram_we_n);

    a_r10_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |=> !ref_gnt);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
    .RASMAX_C  (RASMAX_C),
    .RP_C      (RP_C),
    .RAS_MIN_C (RAS_MIN_C),
    .RCD_C     (RCD_C)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .ref_gnt     (ref_gnt),
    .dram_ras_n  (dram_ras_n),
    .dram_lcas_n (dram_lcas_n),
    .dram_ucas_n (dram_ucas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_oe  (dram_dq_oe)
);

// File: tb/fpm_dram_ctrl_test.sv
module fpm_dram_ctrl_test;
    localparam int B_RP     = 4;
    localparam int B_RCD    = 2;
    localparam int B_CASW   = 2;
    localparam int B_RASMIN = 6;
    localparam int B_RASMAX = 100;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write, rd_valid, ref_req, ref_gnt;
    logic [17:0] req_addr;
    logic [15:0] req_wdata, rd_data, dram_dq_out, dram_dq_in;
    logic [1:0]  req_be;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [8:0]  dram_addr;

    fpm_dram_ctrl #(.T_RASMAX_NS(1000)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // scoreboard queues
    bit          acc_wr[$];
    logic [17:0] acc_addr[$];
    logic [1:0]  acc_be[$];
    logic [15:0] exp_q[$];
    logic [15:0] shadow[int];
    logic [15:0] mem[int];

    // memory model and pin-level timing observer
    int         acts = 0, cbrs = 0, lowc = 0, hic = 100, casc = 0;
    logic       p_ras = 1, p_l = 1, p_u = 1, p_we = 1, p_oe = 1, p_dqoe = 0;
    logic [8:0] cur_row = 0, cur_col = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            lowc = 0; hic = 100; casc = 0;
            p_ras = 1; p_l = 1; p_u = 1; p_we = 1; p_oe = 1; p_dqoe = 0;
            dram_dq_in = 16'h0;
        end else begin
            logic cas_lo, p_cas_lo;
            cas_lo   = !dram_lcas_n || !dram_ucas_n;
            p_cas_lo = !p_l || !p_u;
            if (p_ras && !dram_ras_n) begin
                check(hic >= B_RP, "R7", "precharge cycles", hic, B_RP);
                if (cas_lo) begin
                    cbrs++;
                    check(dram_we_n == 1'b1, "R10", "write enable in refresh", dram_we_n, 1);
                end else begin
                    acts++;
                    cur_row = dram_addr;
                end
            end
            if (!p_ras && dram_ras_n) begin
                check(lowc >= B_RASMIN, "R12", "row strobe low cycles", lowc, B_RASMIN);
                check(lowc <= B_RASMAX, "R9", "row strobe low max", lowc, B_RASMAX);
            end
            if (!p_cas_lo && cas_lo && !dram_ras_n) begin
                check(lowc >= B_RCD, "R8", "RAS to CAS cycles", lowc, B_RCD);
                cur_col = dram_addr;
                if (acc_wr.size() == 0) begin
                    check(0, "R2", "unexpected column access", 0, 0);
                end else begin
                    bit          w;
                    logic [17:0] ea;
                    logic [1:0]  eb;
                    logic [15:0] t;
                    w = acc_wr.pop_front(); ea = acc_addr.pop_front(); eb = acc_be.pop_front();
                    check({cur_row, cur_col} == ea, "R2", "row/column address", {cur_row, cur_col}, ea);
                    check({dram_ucas_n, dram_lcas_n} == (w ? ~eb : 2'b00), "R4", "column strobes",
                          {dram_ucas_n, dram_lcas_n}, w ? ~eb : 2'b00);
                    if (w) begin
                        check(!dram_we_n && !p_we, "R3", "early write enable", {p_we, dram_we_n}, 0);
                        check(dram_oe_n && dram_dq_oe, "R3", "oe high / drive on", {dram_oe_n, dram_dq_oe}, 2'b11);
                        t = mem.exists(int'(ea)) ? mem[int'(ea)] : 16'h0;
                        if (!dram_lcas_n) t[7:0]  = dram_dq_out[7:0];
                        if (!dram_ucas_n) t[15:8] = dram_dq_out[15:8];
                        mem[int'(ea)] = t;
                    end else begin
                        check(!dram_oe_n, "R5", "output enable with read strobe", dram_oe_n, 0);
                    end
                end
            end
            if (p_cas_lo && !cas_lo && !dram_ras_n)
                check(casc >= B_CASW, "R8", "column strobe width", casc, B_CASW);
            if (p_oe && !dram_oe_n)
                check(!p_dqoe, "R11", "drive released before OE", p_dqoe, 0);
            if (dram_dq_oe && !dram_oe_n)
                check(0, "R11", "bus fight", 1, 0);
            if (!dram_oe_n && cas_lo && !dram_ras_n) begin
                int k;
                k = int'({cur_row, cur_col});
                dram_dq_in = mem.exists(k) ? mem[k] : 16'h0;
            end else begin
                dram_dq_in = 16'hDEAD;
            end
            lowc = dram_ras_n ? 0 : lowc + 1;
            hic  = dram_ras_n ? hic + 1 : 0;
            casc = cas_lo ? casc + 1 : 0;
            p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n;
            p_we = dram_we_n; p_oe = dram_oe_n; p_dqoe = dram_dq_oe;
        end
    end

    // read monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R5", "read data with nothing expected", rd_data, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R5", "read data", rd_data, e);
            end
        end
    end

    function automatic logic [17:0] mk(input int r, input int c);
        return {r[8:0], c[8:0]};
    endfunction

    task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] wd, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = wd; req_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc_wr.push_back(w); acc_addr.push_back(a); acc_be.push_back(be);
        if (w) begin
            logic [15:0] t;
            t = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
            if (be[0]) t[7:0]  = wd[7:0];
            if (be[1]) t[15:8] = wd[15:8];
            shadow[int'(a)] = t;
        end else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0);
        end
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] wd, input logic [1:0] be);
        issue(1'b1, a, wd, be);
    endtask
    task automatic rd(input logic [17:0] a);
        issue(1'b0, a, 16'h0, 2'b11);
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_refresh();
        int guard;
        @(negedge clk);
        ref_req = 1;
        #1 check(req_ready == 0, "R10", "ready while refresh pending", req_ready, 0);
        guard = 0;
        while (!ref_gnt && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(ref_gnt == 1, "R10", "grant pulse", ref_gnt, 1);
        ref_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int a0, c0;
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_be = 0;
        ref_req = 0; dram_dq_in = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n} == 5'h1f,
              "R1", "strobes after reset", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n}, 5'h1f);
        check(!dram_dq_oe && !rd_valid && !ref_gnt, "R1", "drive/valid/grant after reset",
              {dram_dq_oe, rd_valid, ref_gnt}, 0);
        check(req_ready == 1, "R1", "ready after reset", req_ready, 1);

        // R2 R5 basic write then read
        wr(mk(5, 3), 16'h1234, 2'b11);
        rd(mk(5, 3));
        idle(10);

        // R6 page hits stay in one row
        a0 = acts;
        wr(mk(5, 10), 16'hBEEF, 2'b11);
        wr(mk(5, 11), 16'h0F0F, 2'b11);
        rd(mk(5, 10));
        rd(mk(5, 11));
        idle(10);
        check(acts == a0, "R6", "activations during page hits", acts, a0);

        // R4 byte lanes
        wr(mk(5, 20), 16'hA1B2, 2'b11);
        wr(mk(5, 20), 16'h00CC, 2'b01);
        rd(mk(5, 20));
        wr(mk(5, 20), 16'h7755, 2'b10);
        rd(mk(5, 20));
        idle(10);

        // R7 row miss reopens
        a0 = acts;
        wr(mk(9, 1), 16'h5A5A, 2'b11);
        rd(mk(5, 3));
        idle(10);
        check(acts == a0 + 2, "R7", "activations after two misses", acts, a0 + 2);

        // R9 idle open row must close on its own
        idle(150);
        check(dram_ras_n == 1, "R9", "row closed after idle", dram_ras_n, 1);

        // R10 refresh from closed row
        c0 = cbrs;
        do_refresh();
        idle(2);
        check(cbrs == c0 + 1, "R10", "refresh cycles seen", cbrs, c0 + 1);

        // R10 refresh with open row, then reopen
        wr(mk(3, 7), 16'hC0DE, 2'b11);
        idle(2);
        c0 = cbrs;
        do_refresh();
        a0 = acts;
        rd(mk(3, 7));
        idle(12);
        check(cbrs == c0 + 1, "R10", "refresh over open row", cbrs, c0 + 1);
        check(acts == a0 + 1, "R7", "reactivation after refresh", acts, a0 + 1);

        // mixed pattern across rows
        for (int i = 0; i < 8; i++)
            wr(mk((i % 3) * 7 + 1, i * 5), 16'h1111 * i[15:0] ^ 16'h0F0F, 2'b11);
        for (int i = 7; i >= 0; i--)
            rd(mk((i % 3) * 7 + 1, i * 5));
        idle(30);
        check(exp_q.size() == 0, "R5", "reads outstanding", exp_q.size(), 0);
        check(acc_wr.size() == 0, "R2", "accesses not seen at pins", acc_wr.size(), 0);
        finish_run();
    end
endmodule